// File: doc/BRIEF.md
# Multiplexed Video Input Formatter

This block takes pixel samples from three 10-bit input ports and loads three per-channel converter code registers. It serves two full-rate colour formats, in which every port carries its own component on every clock, and two chroma-subsampled formats. In the subsampled formats the luma and colour-difference samples arrive interleaved, either spread over two ports or packed onto one port in the single-stream order used by serial digital video. The block tracks the interleave phase, sends each sample to its channel, and holds each colour-difference value for as long as its reduced rate requires.

Phase tracking restarts whenever the active-low blank input is released and whenever the format select changes, so the sample on such an edge is always taken as the blue difference. A delay chain of fixed depth gives each format its own input-to-output latency. The two colour-difference values of a pair are presented together, lined up with the first luma sample of that pair. Overriding the codes for sync and blanking is left to a block downstream.

Top module: `video_input_formatter`

## Requirements
- R1: `fmt_sel` is captured with the data on every rising edge: 2'b00 is full-rate GBR, 2'b01 is full-rate YPbPr, 2'b10 is subsampled over two ports, 2'b11 is subsampled over one port. Both full-rate codes route the data the same way.
- R2: In the full-rate formats, the `in_a`/`in_b`/`in_c` values captured at edge n appear on `out_a`/`out_b`/`out_c` right after edge n+7, with a new value on every clock.
- R3: Every captured sample is given a phase from 0 to 3. The phase is 0 on the first edge after reset, on an edge where `fmt_sel` differs from the previous edge, and on an edge where `blank_n` is high after it was low on the previous edge. On any other edge the phase is the previous phase plus one, modulo 4. `blank_n` affects nothing else.
- R4: In the two-port format, `in_b` (luma) captured at edge n appears on `out_b` right after edge n+8.
- R5: In the two-port format, `in_a` carries the blue difference on even phases and the red difference on odd phases. The blue difference captured at an even-phase edge n and the red difference captured at edge n+1 appear together on `out_c` and `out_a` right after edge n+8, and hold for two clocks. `in_c` is ignored.
- R6: In the one-port format, only `in_b` is used, and it carries blue difference, luma, red difference, luma on phases 0, 1, 2, 3. A luma sample captured at an odd-phase edge n appears on `out_b` right after edge n+8 and holds for two clocks.
- R7: In the one-port format, the blue difference from the phase-0 edge g and the red difference from the phase-2 edge g+2 appear together on `out_c` and `out_a` right after edge g+9, and hold for four clocks. `in_a` and `in_c` are ignored.
- R8: If a restart cuts a pair short, so that the sample that should carry the red difference has phase 0, then `out_a` and `out_c` keep their previous values. Luma still follows R4 or R6.
- R9: When a full-rate update and a subsampled update fall on the same edge, which can happen after a format change, the full-rate update sets all three outputs.
- R10: Reset is synchronous and active high. It clears the outputs to 0, and they stay 0 until the first sample captured after reset reaches them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fmt_sel | input | 2 | Format select (see R1) |
| blank_n | input | 1 | Blank, active low; its release restarts the phase |
| in_a | input | 10 | Red / Pr port; in the two-port format it carries the colour differences |
| in_b | input | 10 | Green / Y port; in the one-port format it carries the whole stream |
| in_c | input | 10 | Blue / Pb port |
| out_a | output | 10 | Red / Pr channel code |
| out_b | output | 10 | Green / Y channel code |
| out_c | output | 10 | Blue / Pb channel code |

## Verification
The results fall due at different times. A full-rate sample is due on the outputs 7 edges after it is captured. Luma is due 8 edges after capture in both subsampled formats. A two-port colour pair is due 8 edges after its blue-difference edge, and a one-port pair 9 edges after its phase-0 edge. The bench keeps a history of every captured sample together with the phase it assigns from the rules. After each edge t it works out the expected outputs from the samples captured at t-7, t-8 and t-9. It drives inputs and compares all three outputs at the falling edge, so each comparison sees the state right after the edge that loaded it. Each comparison is tagged with the rule that last set that channel, so a held value after a cut-short pair or a full-rate override is reported against its own requirement.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

    localparam int unsigned PIX_W      = 10;
    localparam int unsigned PH_W       = 2;
    localparam int unsigned LAT_FULL   = 7;
    localparam int unsigned LAT_PAIR   = 8;
    localparam int unsigned LAT_SERIAL = 9;
    localparam int unsigned CHAIN_D    = LAT_SERIAL;
    localparam int unsigned CNT_W      = $clog2(LAT_SERIAL + 2) + 1;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [1:0] {
        FMT_GBR    = 2'b00,
        FMT_YUV444 = 2'b01,
        FMT_SUB2P  = 2'b10,
        FMT_SUB1P  = 2'b11
    } fmt_e;

    // one captured input sample with its format and interleave phase
    typedef struct packed {
        logic            vld;
        logic            blk;
        fmt_e            fmt;
        logic [PH_W-1:0] ph;
        pix_t            a;
        pix_t            b;
        pix_t            c;
    } rec_t;

    function automatic logic is_full(fmt_e f);
        return !f[1];
    endfunction

    // the phase goes back to zero after reset, on a format change, or on blank release
    function automatic logic phase_restart(rec_t prev, fmt_e f, logic blank_n);
        return !prev.vld || (f != prev.fmt) || (blank_n && !prev.blk);
    endfunction

endpackage

// File: rtl/vfmt_capture.sv
module vfmt_capture
    import vfmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] fmt_sel,
    input  logic       blank_n,
    input  pix_t       in_a,
    input  pix_t       in_b,
    input  pix_t       in_c,
    input  rec_t       prev,
    output rec_t       rec_d
);

    fmt_e fmt_now;
    assign fmt_now = fmt_e'(fmt_sel);

    always_comb begin
        rec_d     = '0;
        rec_d.vld = 1'b1;
        rec_d.blk = blank_n;
        rec_d.fmt = fmt_now;
        rec_d.ph  = phase_restart(prev, fmt_now, blank_n) ? '0 : prev.ph + PH_W'(1);
        rec_d.a   = in_a;
        rec_d.b   = in_b;
        rec_d.c   = in_c;
    end

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (prev.vld && blank_n && !prev.blk) |=> (prev.ph == '0)); // R3

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (prev.vld && (fmt_now == prev.fmt) && !(blank_n && !prev.blk))
        |=> (prev.ph == $past(prev.ph) + PH_W'(1))); // R3

endmodule

// File: rtl/vfmt_delay.sv
module vfmt_delay
    import vfmt_pkg::*;
#(
    parameter int unsigned DEPTH = CHAIN_D
)
(
    input  logic clk,
    input  logic rst,
    input  rec_t d_in,
    output rec_t tap [1:DEPTH]
);

    // tap[k] holds the record captured k edges before the current one
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 1; k <= DEPTH; k++) tap[k] <= '0;
        end else begin
            tap[1] <= d_in;
            for (int k = 2; k <= DEPTH; k++) tap[k] <= tap[k-1];
        end
    end

endmodule

// File: rtl/vfmt_assemble.sv
module vfmt_assemble
    import vfmt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rec_t rec_near,
    input  rec_t rec_mid,
    input  rec_t rec_far,
    output pix_t out_a,
    output pix_t out_b,
    output pix_t out_c
);

    logic full_hit;
    logic y_hit;
    logic c_hit;
    pix_t c_pb;
    pix_t c_pr;
    logic near_full;

    assign near_full = rec_near.vld && is_full(rec_near.fmt);
    assign full_hit  = near_full;

    always_comb begin
        y_hit = 1'b0;
        c_hit = 1'b0;
        c_pb  = rec_mid.a;
        c_pr  = rec_near.a;
        if (rec_mid.vld) begin
            case (rec_mid.fmt)
                FMT_SUB2P: begin
                    y_hit = 1'b1;
                    c_hit = !rec_mid.ph[0] && rec_near.vld &&
                            (rec_near.fmt == FMT_SUB2P) && rec_near.ph[0];
                    c_pb  = rec_mid.a;
                    c_pr  = rec_near.a;
                end
                FMT_SUB1P: begin
                    y_hit = rec_mid.ph[0];
                    c_hit = (rec_mid.ph == PH_W'(1)) && rec_near.vld &&
                            (rec_near.fmt == FMT_SUB1P) && (rec_near.ph == PH_W'(2));
                    c_pb  = rec_far.b;
                    c_pr  = rec_near.b;
                end
                default: begin
                    y_hit = 1'b0;
                    c_hit = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_a <= '0;
            out_b <= '0;
            out_c <= '0;
        end else if (full_hit) begin
            out_a <= rec_near.a;
            out_b <= rec_near.b;
            out_c <= rec_near.c;
        end else begin
            if (y_hit) out_b <= rec_mid.b;
            if (c_hit) begin
                out_a <= c_pr;
                out_c <= c_pb;
            end
        end
    end

    AST_SERIAL_Y_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rec_mid.vld && (rec_mid.fmt == FMT_SUB1P) && !rec_mid.ph[0] && !near_full)
        |=> $stable(out_b)); // R6

    AST_PAIR_CHROMA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rec_mid.vld && (rec_mid.fmt == FMT_SUB2P) && rec_mid.ph[0] && !near_full)
        |=> ($stable(out_a) && $stable(out_c))); // R5

    AST_CUT_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rec_mid.vld && (rec_mid.fmt == FMT_SUB2P) && !rec_mid.ph[0] &&
         rec_near.vld && (rec_near.fmt == FMT_SUB2P) && (rec_near.ph == '0))
        |=> ($stable(out_a) && $stable(out_c))); // R8

endmodule

// File: rtl/video_input_formatter.sv
module video_input_formatter
    import vfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       fmt_sel,
    input  logic             blank_n,
    input  logic [PIX_W-1:0] in_a,
    input  logic [PIX_W-1:0] in_b,
    input  logic [PIX_W-1:0] in_c,
    output logic [PIX_W-1:0] out_a,
    output logic [PIX_W-1:0] out_b,
    output logic [PIX_W-1:0] out_c
);

    rec_t rec_new;
    rec_t tap [1:CHAIN_D];

    vfmt_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .fmt_sel (fmt_sel),
        .blank_n (blank_n),
        .in_a    (in_a),
        .in_b    (in_b),
        .in_c    (in_c),
        .prev    (tap[1]),
        .rec_d   (rec_new)
    );

    vfmt_delay #(.DEPTH(CHAIN_D)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .d_in (rec_new),
        .tap  (tap)
    );

    vfmt_assemble u_assemble (
        .clk      (clk),
        .rst      (rst),
        .rec_near (tap[LAT_FULL]),
        .rec_mid  (tap[LAT_PAIR]),
        .rec_far  (tap[LAT_SERIAL]),
        .out_a    (out_a),
        .out_b    (out_b),
        .out_c    (out_c)
    );

    // edges since reset release, saturating; bounds the look-back of the latency check
    logic [CNT_W-1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                      since_rst <= '0;
        else if (since_rst != '1)     since_rst <= since_rst + CNT_W'(1);
    end

    AST_FULL_LATENCY: assert property (@(posedge clk) disable iff (rst)
        ((since_rst >= CNT_W'(LAT_FULL + 1)) && !$past(fmt_sel[1], LAT_FULL + 1))
        |-> ((out_a == $past(in_a, LAT_FULL + 1)) &&
             (out_b == $past(in_b, LAT_FULL + 1)) &&
             (out_c == $past(in_c, LAT_FULL + 1)))); // R2

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((out_a == '0) && (out_b == '0) && (out_c == '0))); // R10

endmodule

// File: tb/tb_video_input_formatter.sv
`timescale 1ns/1ps
module tb_video_input_formatter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] fmt_sel = 2'b00;
    logic       blank_n = 1'b0;
    logic [9:0] in_a = '0, in_b = '0, in_c = '0;
    logic [9:0] out_a, out_b, out_c;

    always #2 clk = ~clk;

    video_input_formatter dut (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .blank_n(blank_n),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_a(out_a), .out_b(out_b), .out_c(out_c)
    );

    typedef struct {
        bit vld; bit blk; int fmt; int ph; int a; int b; int c;
    } mrec_t;

    mrec_t hist[$];
    int    checks = 0;
    int    errors = 0;
    int    ea = 0, eb = 0, ec = 0;
    string ta = "R10", tb = "R10", tc = "R10";
    bit    started = 0;
    bit    done = 0;

    function automatic mrec_t at(int idx);
        mrec_t z;
        z = '{vld:0, blk:0, fmt:0, ph:0, a:0, b:0, c:0};
        if (idx < 0 || idx >= hist.size()) return z;
        return hist[idx];
    endfunction

    task automatic chk(string tag, string name, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d at %0t", tag, name, got, exp, $time);
        end
    endtask

    task automatic compare();
        chk(ta, "out_a", int'(out_a), ea);
        chk(tb, "out_b", int'(out_b), eb);
        chk(tc, "out_c", int'(out_c), ec);
    endtask

    // expected outputs right after edge e, from the samples captured 7, 8 and 9 edges earlier
    task automatic predict(int e);
        mrec_t near, mid, far;
        near = at(e - 7);
        mid  = at(e - 8);
        far  = at(e - 9);
        if (mid.vld && mid.fmt == 2) begin
            eb = mid.b; tb = "R4";
            if (mid.ph % 2 == 0) begin
                if (near.vld && near.fmt == 2 && near.ph % 2 == 1) begin
                    ec = mid.a; ea = near.a; ta = "R3 R5"; tc = "R3 R5";
                end else begin
                    ta = "R8"; tc = "R8";
                end
            end
        end
        if (mid.vld && mid.fmt == 3) begin
            if (mid.ph % 2 == 1) begin eb = mid.b; tb = "R6"; end
            if (mid.ph == 1) begin
                if (near.vld && near.fmt == 3 && near.ph == 2) begin
                    ec = far.b; ea = near.b; ta = "R3 R7"; tc = "R3 R7";
                end else begin
                    ta = "R8"; tc = "R8";
                end
            end
        end
        if (near.vld && near.fmt < 2) begin
            string t;
            if (mid.vld && mid.fmt >= 2) t = "R9";
            else if (near.fmt == 0)     t = "R2";
            else                        t = "R1";
            ea = near.a; eb = near.b; ec = near.c;
            ta = t; tb = t; tc = t;
        end
    endtask

    task automatic step(bit r, int f, bit bl, int a, int b, int c);
        mrec_t prev, n;
        @(negedge clk);
        if (started) compare();
        started = 1;
        rst = r; fmt_sel = 2'(f); blank_n = bl;
        in_a = 10'(a); in_b = 10'(b); in_c = 10'(c);
        prev = at(hist.size() - 1);
        n = '{vld:0, blk:0, fmt:0, ph:0, a:0, b:0, c:0};
        if (r) begin
            hist.push_back(n);
            ea = 0; eb = 0; ec = 0; ta = "R10"; tb = "R10"; tc = "R10";
        end else begin
            n.vld = 1; n.blk = bl; n.fmt = f;
            n.ph  = (!prev.vld || f != prev.fmt || (bl && !prev.blk)) ? 0 : (prev.ph + 1) % 4;
            n.a = a; n.b = b; n.c = c;
            hist.push_back(n);
            predict(hist.size() - 1);
        end
    endtask

    task automatic seg(int f, int cnt, int pblank);
        for (int i = 0; i < cnt; i++)
            step(0, f, (($urandom % 100) >= pblank), $urandom % 1024, $urandom % 1024, $urandom % 1024);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0);      // R10 reset state
        seg(0, 30, 0);                                            // R2 GBR pass
        seg(1, 30, 20);                                           // R1 YPbPr full rate, blank pulses
        seg(2, 60, 15);                                           // R4 R5 R8 two-port
        seg(3, 80, 15);                                           // R6 R7 R8 one-port
        seg(2, 20, 0);
        seg(0, 12, 0);                                            // R9 switch to full rate
        seg(3, 40, 10);
        seg(1, 10, 0);                                            // R9
        for (int k = 0; k < 150; k++) seg($urandom % 4, 4 + $urandom % 30, $urandom % 25);
        seg(0, 12, 0);
        @(negedge clk);
        compare();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 got running expected finished");
            summary();
            $finish;
        end
    end

endmodule